// File: doc/BRIEF.md
# Latched Jump Motion Controller

This block sets the vertical position of a player sprite in a side-view game. One tap on the jump button starts a complete arc. The sprite climbs in fixed steps to an apex line, then drops back to the floor. A flag that is raised by the tap and lowered only on landing keeps the arc going. Holding or releasing the button while the sprite is airborne has no effect.

All motion happens on a game tick. The tick is an enable pulse derived from the system clock by a half-period counter, about 60 Hz from 100 MHz with the default count. The bench makes the count small. Both buttons pass through two-flop synchronisers. A jump press is the 0-to-1 change of the synchronised level between two ticks. A home button puts the sprite back at its start point, and it takes priority over any jump activity.

There is no data stream here, so no port uses a valid/ready handshake. Every pin is a plain control or status level.

Top module: `hop_motion_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no button activity, `pos_x` is 503 and `pos_y` is the grounded value 664. That value is floor line 696 minus sprite height 32.
- R2: `pos_y` changes only on a game tick. Ticks are exactly 2*(TICK_HALF+1) clock cycles apart.
- R3: A jump press is a 0-to-1 change of the synchronised button between consecutive ticks, accepted only while grounded. The first upward step of 10 (664 to 654) happens on the first tick that sees it. That is 3 to 2*(TICK_HALF+1)+2 cycles after the raw input rises.
- R4: While rising, `pos_y` drops by STEP (10) per tick. The smallest value it reaches is exactly the apex 164, and after that the sprite falls without any input.
- R5: While falling, `pos_y` grows by STEP per tick until it is back at 664. With the default geometry, the landing tick is the 100th tick counted from the press tick, which is tick 1.
- R6: A step that would pass the apex or the grounded line is clamped to that line. With STEP = 15 the arc still peaks at exactly 164 and lands at exactly 664, the last step each way is 5, and the whole jump takes 68 ticks.
- R7: Presses and releases while airborne neither restart nor lengthen the arc. The jump still takes 100 ticks. A falling sprite never turns back to rising.
- R8: A button still held at landing does not start a new jump. `pos_y` stays at 664 until the button is released and pressed again.
- R9: On a tick where the synchronised home button is 1, the sprite goes to (503, 664) and is grounded, even in mid-air and even when a jump press arrives on the same tick.
- R10: `pos_x` stays at 503 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| btn_jump | input | 1 | Raw jump button, asynchronous |
| btn_home | input | 1 | Raw home button, asynchronous, highest priority |
| pos_x | output | 11 | Registered sprite X |
| pos_y | output | 11 | Registered sprite top-edge Y (smaller is higher) |

## Verification
The assertions assume the buttons are plain levels. They may be asynchronous, but they must hold steady long enough for a two-flop synchroniser to capture them, and the geometry parameters must satisfy apex + step below grounded − step. The bench changes the buttons only on falling clock edges. It holds every press for at least two tick periods and keeps the button low for at least two ticks before a new press, so every intended edge is seen at a tick. Mid-air toggles are deliberately faster than the tick, to show that any edge they produce is ignored.

// File: rtl/hop_pkg.sv
package hop_pkg;
  typedef enum logic [1:0] {
    HOP_GROUND = 2'd0,
    HOP_RISE   = 2'd1,
    HOP_FALL   = 2'd2
  } hop_state_e;
endpackage

// File: rtl/hop_tick_div.sv
module hop_tick_div #(
  parameter int unsigned TICK_HALF = 833333
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_HALF < 1) ? 1 : $clog2(TICK_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_HALF);

  logic [CW-1:0] cnt;
  logic          phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // one pulse per full divided period: the low-to-high turn of phase
  assign tick = (cnt == LAST) && !phase;
endmodule

// File: rtl/hop_btn_sync.sv
module hop_btn_sync #(
  parameter int unsigned NBTN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NBTN-1:0] raw,
  output logic [NBTN-1:0] level,
  output logic [NBTN-1:0] press
);
  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    logic meta, sync, last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        sync <= 1'b0;
        last <= 1'b0;
      end else begin
        meta <= raw[i];
        sync <= meta;
        if (tick) last <= sync;
      end
    end
    assign level[i] = sync;
    assign press[i] = tick && sync && !last;
  end
endmodule

// File: rtl/hop_arc.sv
module hop_arc
  import hop_pkg::*;
#(
  parameter int unsigned POS_W    = 11,
  parameter int unsigned GROUND_Y = 664,
  parameter int unsigned APEX_Y   = 164,
  parameter int unsigned STEP     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             home,
  input  logic             tap,
  output logic [POS_W-1:0] y,
  output hop_state_e       state
);
  localparam logic [POS_W-1:0] GND  = POS_W'(GROUND_Y);
  localparam logic [POS_W-1:0] APX  = POS_W'(APEX_Y);
  localparam logic [POS_W-1:0] STP  = POS_W'(STEP);
  localparam logic [POS_W:0]   UP_LIM = (POS_W+1)'(APEX_Y + STEP);
  localparam logic [POS_W:0]   DN_LIM = (POS_W+1)'(GROUND_Y - STEP);

  logic [POS_W-1:0] up_y, dn_y;
  hop_state_e       up_st, dn_st;

  always_comb begin
    if ({1'b0, y} <= UP_LIM) begin
      up_y  = APX;
      up_st = HOP_FALL;
    end else begin
      up_y  = y - STP;
      up_st = HOP_RISE;
    end
    if ({1'b0, y} >= DN_LIM) begin
      dn_y  = GND;
      dn_st = HOP_GROUND;
    end else begin
      dn_y  = y + STP;
      dn_st = HOP_FALL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y     <= GND;
      state <= HOP_GROUND;
    end else if (tick) begin
      if (home) begin
        y     <= GND;
        state <= HOP_GROUND;
      end else begin
        unique case (state)
          HOP_GROUND: if (tap) begin
            y     <= up_y;
            state <= up_st;
          end
          HOP_RISE: begin
            y     <= up_y;
            state <= up_st;
          end
          HOP_FALL: begin
            y     <= dn_y;
            state <= dn_st;
          end
          default: begin
            y     <= GND;
            state <= HOP_GROUND;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/hop_motion_ctrl.sv
module hop_motion_ctrl
  import hop_pkg::*;
#(
  parameter int unsigned POS_W     = 11,
  parameter int unsigned TICK_HALF = 833333,
  parameter int unsigned FLOOR_Y   = 696,
  parameter int unsigned SPRITE_H  = 32,
  parameter int unsigned APEX_Y    = 164,
  parameter int unsigned STEP      = 10,
  parameter int unsigned START_X   = 503
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_jump,
  input  logic             btn_home,
  output logic [POS_W-1:0] pos_x,
  output logic [POS_W-1:0] pos_y
);
  localparam int unsigned GROUND_Y = FLOOR_Y - SPRITE_H;
  localparam int unsigned B_JUMP = 0;
  localparam int unsigned B_HOME = 1;

  logic       tick_en;
  logic [1:0] btn_lvl, btn_press;
  logic       home_lvl;
  hop_state_e arc_state;

  hop_tick_div #(.TICK_HALF(TICK_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_en)
  );

  hop_btn_sync #(.NBTN(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .raw({btn_home, btn_jump}), .level(btn_lvl), .press(btn_press)
  );

  assign home_lvl = btn_lvl[B_HOME];

  hop_arc #(
    .POS_W(POS_W), .GROUND_Y(GROUND_Y), .APEX_Y(APEX_Y), .STEP(STEP)
  ) u_arc (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .home(home_lvl),
    .tap(btn_press[B_JUMP]), .y(pos_y), .state(arc_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_x <= POS_W'(START_X);
    else if (tick_en && home_lvl) pos_x <= POS_W'(START_X);
  end
endmodule

// File: rtl/hop_motion_chk.sv
module hop_motion_chk
  import hop_pkg::*;
#(
  parameter int unsigned POS_W    = 11,
  parameter int unsigned GROUND_Y = 664,
  parameter int unsigned APEX_Y   = 164,
  parameter int unsigned STEP     = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             home,
  input hop_state_e       state,
  input logic [POS_W-1:0] pos_y
);
  assert_y_in_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pos_y) >= int'(APEX_Y)) && (int'(pos_y) <= int'(GROUND_Y)));

  assert_move_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos_y));

  assert_rise_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !home && state == HOP_RISE) |=>
      (pos_y < $past(pos_y)) && (int'($past(pos_y)) - int'(pos_y) <= int'(STEP)));

  assert_fall_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !home && state == HOP_FALL) |=>
      (pos_y > $past(pos_y)) && (int'(pos_y) - int'($past(pos_y)) <= int'(STEP)));

  assert_home_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && home) |=> (int'(pos_y) == int'(GROUND_Y)) && (state == HOP_GROUND));

  assert_no_turnback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HOP_FALL) |=> (state != HOP_RISE));
endmodule

bind hop_motion_ctrl hop_motion_chk #(
  .POS_W(POS_W), .GROUND_Y(GROUND_Y), .APEX_Y(APEX_Y), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_en), .home(home_lvl),
  .state(arc_state), .pos_y(pos_y)
);

// File: tb/hop_motion_ctrl_bench.sv
module hop_motion_ctrl_bench;
  localparam int HALF   = 2;
  localparam int PERIOD = 2 * (HALF + 1);
  localparam int GND    = 664;
  localparam int APEX   = 164;
  localparam int HOMEX  = 503;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_jump = 1'b0;
  logic btn_home = 1'b0;
  logic [10:0] xa, ya, xb, yb;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hop_motion_ctrl #(.TICK_HALF(HALF)) u_hop_motion_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_jump(btn_jump), .btn_home(btn_home),
    .pos_x(xa), .pos_y(ya)
  );

  hop_motion_ctrl #(.TICK_HALF(HALF), .STEP(15)) u_hop_motion_ctrl_odd (
    .clk(clk), .rst_n(rst_n), .btn_jump(btn_jump), .btn_home(btn_home),
    .pos_x(xb), .pos_y(yb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int obs_y(input bit sel);
    return sel ? int'(yb) : int'(ya);
  endfunction

  task automatic idle_ticks(input int n);
    repeat (n * PERIOD) @(negedge clk);
  endtask

  // Press jump, follow one arc of the selected instance until it lands.
  // hold_ticks = 0 keeps the button held; toggle = 1 chatters it mid-air.
  task automatic run_arc(input bit sel, input int hold_ticks, input bit toggle,
                         output int dur, output int miny, output int first_y,
                         output int latency, output int badgap, output int maxstep);
    int tp, t0, tl, prev, nchg;
    bit started;
    @(negedge clk);
    btn_jump = 1'b1;
    tp = cyc; prev = GND; started = 0; nchg = 0;
    dur = 0; miny = GND; first_y = -1; latency = -1; badgap = 0; maxstep = 0;
    t0 = 0; tl = 0;
    for (int k = 0; k < 400 * PERIOD; k++) begin
      @(negedge clk);
      if (hold_ticks != 0 && cyc - tp == hold_ticks * PERIOD && !toggle) btn_jump = 1'b0;
      if (toggle) begin
        if (nchg >= 20 && nchg < 40) btn_jump = ((cyc % 7) < 3);
        else if (nchg >= 40) btn_jump = 1'b0;
      end
      if (obs_y(sel) != prev) begin
        if (!started) begin
          started = 1; t0 = cyc; first_y = obs_y(sel); latency = cyc - tp;
        end else if (cyc - tl != PERIOD) badgap++;
        if (((obs_y(sel) > prev) ? obs_y(sel) - prev : prev - obs_y(sel)) > maxstep)
          maxstep = (obs_y(sel) > prev) ? obs_y(sel) - prev : prev - obs_y(sel);
        tl = cyc; nchg++;
        if (obs_y(sel) < miny) miny = obs_y(sel);
        prev = obs_y(sel);
        if (prev == GND) begin
          dur = (cyc - t0) / PERIOD + 1;
          break;
        end
      end
    end
    if (hold_ticks != 0 || toggle) btn_jump = 1'b0;
  endtask

  task automatic t_reset;
    check(int'(xa) == HOMEX, "R1 x in reset", int'(xa), HOMEX);
    check(int'(ya) == GND, "R1 y in reset", int'(ya), GND);
    rst_n = 1'b1;
    idle_ticks(4);
    check(int'(ya) == GND, "R1 y after reset", int'(ya), GND);
    check(int'(xa) == HOMEX, "R10 x after reset", int'(xa), HOMEX);
  endtask

  task automatic t_basic;
    int dur, miny, fy, lat, gap, mx;
    run_arc(1'b0, 2, 1'b0, dur, miny, fy, lat, gap, mx);
    check(fy == 654, "R3 first step", fy, 654);
    check(lat >= 3 && lat <= PERIOD + 2, "R3 press latency", lat, PERIOD + 2);
    check(miny == APEX, "R4 apex", miny, APEX);
    check(mx == 10, "R4 step size", mx, 10);
    check(gap == 0, "R2 tick spacing", gap, 0);
    check(dur == 100, "R5 jump ticks", dur, 100);
    check(int'(ya) == GND, "R5 landed", int'(ya), GND);
    check(int'(xa) == HOMEX, "R10 x during jump", int'(xa), HOMEX);
    idle_ticks(3);
  endtask

  task automatic t_midair;
    int dur, miny, fy, lat, gap, mx;
    run_arc(1'b0, 0, 1'b1, dur, miny, fy, lat, gap, mx);
    check(dur == 100, "R7 mid-air presses ignored", dur, 100);
    check(miny == APEX, "R7 apex unchanged", miny, APEX);
    idle_ticks(3);
  endtask

  task automatic t_hold;
    int dur, miny, fy, lat, gap, mx;
    run_arc(1'b0, 0, 1'b0, dur, miny, fy, lat, gap, mx);
    check(dur == 100, "R8 held arc length", dur, 100);
    idle_ticks(10);
    check(int'(ya) == GND, "R8 no retrigger while held", int'(ya), GND);
    btn_jump = 1'b0;
    idle_ticks(3);
    check(int'(ya) == GND, "R8 release alone no jump", int'(ya), GND);
  endtask

  task automatic t_home;
    int dur, miny, fy, lat, gap, mx;
    @(negedge clk);
    btn_jump = 1'b1;
    idle_ticks(20);
    btn_jump = 1'b0;
    check(int'(ya) < GND, "R9 airborne before home", int'(ya), GND - 1);
    btn_home = 1'b1;
    idle_ticks(2);
    check(int'(ya) == GND, "R9 home mid-air y", int'(ya), GND);
    check(int'(xa) == HOMEX, "R9 home x", int'(xa), HOMEX);
    btn_jump = 1'b1;
    idle_ticks(4);
    check(int'(ya) == GND, "R9 home beats press", int'(ya), GND);
    btn_jump = 1'b0;
    btn_home = 1'b0;
    idle_ticks(3);
    check(int'(ya) == GND, "R9 grounded after home", int'(ya), GND);
    run_arc(1'b0, 2, 1'b0, dur, miny, fy, lat, gap, mx);
    check(dur == 100, "R9 normal jump after home", dur, 100);
    idle_ticks(3);
  endtask

  task automatic t_clamp;
    int dur, miny, fy, lat, gap, mx;
    run_arc(1'b1, 2, 1'b0, dur, miny, fy, lat, gap, mx);
    check(miny == APEX, "R6 clamped apex", miny, APEX);
    check(dur == 68, "R6 clamped ticks", dur, 68);
    check(int'(yb) == GND, "R6 clamped landing", int'(yb), GND);
    check(mx == 15, "R6 largest step", mx, 15);
    idle_ticks(60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_midair();
    t_hold();
    t_home();
    t_clamp();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule